// File: doc/BRIEF.md
# Synchronous Audio Bus Lane Transmitter

This block puts the audio samples of one node onto a shared multi-drop bus of eight serial lanes. A single frame strobe at 48 kHz paces the whole bus. A host loads 24-bit sample words into two buffer slots through a simple write port. On each rising edge of the strobe the block copies the buffered words into frame registers. It then shifts each word out on the lane or lanes that this node owns.

Every frame carries only the upper 16 bits of a written word. A frame is one idle bit, a low start bit, the 16 data bits least significant first and an even-parity bit. Each bit lasts `BIT_CYC` clock cycles. With a 48 MHz clock and `BIT_CYC` = 32, the frame ends well before the next strobe period of 1000 cycles.

The low three bits of a 4-bit node address decide which lanes the node may drive. Node 0 drives two lanes. Nodes 1 to 6 each drive one lane. Node 7 drives none. Each lane has its own output enable, so only the owner of a lane drives it.

Top module: `abus_tx_top`

## Requirements
- R1: While reset is asserted, every `lane_out` bit is 1 and every `lane_oe` bit is 0. After reset, and before the first strobe, every `lane_out` bit stays at 1.
- R2: `lane_oe` follows `node_addr[2:0]` one clock after it is applied. Value 0 gives lanes 0 and 1. A value n from 1 to 6 gives only lane n+1. Value 7 gives no lane. `node_addr[3]` has no effect.
- R3: A lane whose enable is 0 is held at 1. Every lane is at 1 whenever no frame is in progress.
- R4: The strobe is an asynchronous input and must be set away from a clock edge. The idle bit (1) starts on the fourth rising clock edge after the strobe goes high. Then follow the start bit (0), data bits 0 to 15 and the parity bit. Each bit lasts exactly `BIT_CYC` cycles. After that the lane returns to 1.
- R5: The 16 data bits of a frame are bits 23 to 8 of the written word. Bits 7 to 0 have no effect on any lane.
- R6: The parity bit makes the number of ones among the 16 data bits and the parity bit even.
- R7: `wr_slot` = 0 selects slot 0 and `wr_slot` = 1 selects slot 1. Node 0 sends slot 0 on lane 0 and slot 1 on lane 1. Nodes 1 to 6 send slot 0 on their single lane. Writes to slot 1 never appear on any lane of a node other than node 0.
- R8: A frame carries the last word written to its slot before the strobe. A later write before the strobe replaces an earlier one. A write made while a frame is being shifted does not change that frame and is sent in the next frame.
- R9: If a slot is not written again, the next frame sends the same word again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (48 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | 48 kHz frame strobe, asynchronous to clk |
| node_addr | input | 4 | Node address; bits 2:0 select lane ownership |
| wr_en | input | 1 | Buffer write strobe, one word per cycle |
| wr_slot | input | 1 | Buffer slot selected for the write |
| wr_data | input | 24 | Sample word; bits 23:8 are transmitted |
| lane_out | output | 8 | Serial data per bus lane, idle high |
| lane_oe | output | 8 | Per-lane drive enable |

## Verification
The bench builds the block with `BIT_CYC` = 4, so a frame is only 76 cycles. This short frame makes it cheap to run one frame for each of the 16 node addresses, and to run walking-one and mixed data patterns on both master and single-lane nodes. The bench samples every bit of every lane in the middle of its bit window. It also checks the three buffer orderings: a write replaced before the strobe, a write made during a frame, and a frame with no new write.

// File: rtl/abus_tx_pkg.sv
package abus_tx_pkg;

  localparam int LANES      = 8;
  localparam int SLOTS      = 2;
  localparam int NODE_SEL_W = 3;
  localparam logic [NODE_SEL_W-1:0] MASTER_NODE = 3'd0;
  localparam logic [NODE_SEL_W-1:0] SILENT_NODE = 3'd7;

  typedef struct packed {
    logic used;
    logic slot;
  } lane_route_t;

  // Which buffer slot, if any, feeds a given lane for a given node.
  function automatic lane_route_t route_lane(input logic [NODE_SEL_W-1:0] node,
                                             input int lane);
    lane_route_t r;
    r.used = 1'b0;
    r.slot = 1'b0;
    if (node == MASTER_NODE) begin
      if (lane < SLOTS) begin
        r.used = 1'b1;
        r.slot = (lane == 1);
      end
    end else if (node != SILENT_NODE) begin
      if (lane == int'(node) + 1) begin
        r.used = 1'b1;
        r.slot = 1'b0;
      end
    end
    return r;
  endfunction

  // Number of lanes a node owns.
  function automatic int lanes_owned(input logic [NODE_SEL_W-1:0] node);
    if (node == MASTER_NODE) return SLOTS;
    else if (node == SILENT_NODE) return 0;
    else return 1;
  endfunction

endpackage

// File: rtl/abus_strobe_sync.sv
module abus_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic strobe_rise
);
  logic [2:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], strobe_async};
  end

  assign strobe_rise = sync_q[1] & ~sync_q[2];

  // R4: an edge is reported for exactly one cycle
  p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> !strobe_rise);

endmodule

// File: rtl/abus_bit_timer.sv
module abus_bit_timer #(
  parameter int BIT_CYC    = 32,
  parameter int FRAME_BITS = 19,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int CYC_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(BIT_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [CYC_W-1:0] cyc_q;
  logic             bit_end;

  assign bit_end = active && (cyc_q == CYC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cyc_q   <= '0;
      bit_idx <= '0;
    end else if (start) begin
      active  <= 1'b1;
      cyc_q   <= '0;
      bit_idx <= '0;
    end else if (active) begin
      if (bit_end) begin
        cyc_q <= '0;
        if (bit_idx == IDX_LAST) active  <= 1'b0;
        else                     bit_idx <= bit_idx + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  // R4: the bit index only moves at the end of a bit window
  p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && !bit_end) |=> $stable(bit_idx));

  // R4: consecutive bits in order
  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && !start && bit_idx != IDX_LAST) |=> (bit_idx == $past(bit_idx) + 1'b1));

  // R4: the frame stops after its last bit
  p_frame_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && !start && bit_idx == IDX_LAST) |=> !active);

endmodule

// File: rtl/abus_tx_buffer.sv
module abus_tx_buffer #(
  parameter int SAMPLE_W = 24,
  parameter int DATA_W   = 16,
  parameter int SLOTS    = 2,
  parameter int SLOT_W   = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SLOT_W-1:0]            wr_slot,
  input  logic [SAMPLE_W-1:0]          wr_data,
  input  logic                         capture,
  output logic [SLOTS-1:0][DATA_W-1:0] frame_words
);
  localparam int DROP_W = SAMPLE_W - DATA_W;

  // Upper part of a host word is the transmitted sample.
  function automatic logic [DATA_W-1:0] bus_sample(input logic [SAMPLE_W-1:0] w);
    return w[SAMPLE_W-1 -: DATA_W];
  endfunction

  logic [SLOTS-1:0][DATA_W-1:0] pend_q;
  logic                         unused_low_bits;

  assign unused_low_bits = ^wr_data[DROP_W-1:0];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_q[s] <= '0;
      else if (wr_en && (wr_slot == SLOT_W'(s)))
        pend_q[s] <= bus_sample(wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frame_words <= '0;
    else if (capture) frame_words <= pend_q;
  end

  // R8: the words in flight move only on a strobe edge
  p_frame_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(frame_words));

  // R9: without a host write the pending words persist
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pend_q));

endmodule

// File: rtl/abus_frame_ser.sv
module abus_frame_ser #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic              bit_val
);
  // Frame layout: idle 1, start 0, data LSB first, even parity.
  function automatic logic frame_bit(input logic [DATA_W-1:0] d,
                                     input logic [IDX_W-1:0]  k);
    int pos;
    pos = int'(k);
    if (pos == 0)               return 1'b1;
    else if (pos == 1)          return 1'b0;
    else if (pos < DATA_W + 2)  return d[pos - 2];
    else                        return ^d;
  endfunction

  assign bit_val = frame_bit(word, bit_idx);

endmodule

// File: rtl/abus_lane_drive.sv
module abus_lane_drive
  import abus_tx_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int N_SLOTS = SLOTS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NODE_SEL_W-1:0] node_sel,
  input  logic                  active,
  input  logic [N_SLOTS-1:0]    slot_bits,
  output logic [N_LANES-1:0]    lane_out,
  output logic [N_LANES-1:0]    lane_oe
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    lane_route_t rt;
    assign rt = route_lane(node_sel, l);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_out[l] <= 1'b1;
        lane_oe[l]  <= 1'b0;
      end else begin
        lane_oe[l]  <= rt.used;
        lane_out[l] <= (rt.used && active) ? slot_bits[rt.slot] : 1'b1;
      end
    end
  end

endmodule

// File: rtl/abus_tx_top.sv
module abus_tx_top
  import abus_tx_pkg::*;
#(
  parameter int BIT_CYC  = 32,
  parameter int SAMPLE_W = 24,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_strobe,
  input  logic [ADDR_W-1:0]   node_addr,
  input  logic                wr_en,
  input  logic                wr_slot,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic [LANES-1:0]    lane_out,
  output logic [LANES-1:0]    lane_oe
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int SLOT_W     = 1;

  logic                         strobe_rise;
  logic                         frame_active;
  logic [IDX_W-1:0]             bit_idx;
  logic [SLOTS-1:0][DATA_W-1:0] frame_words;
  logic [SLOTS-1:0]             slot_bits;
  logic [NODE_SEL_W-1:0]        node_sel;
  logic                         unused_addr_bits;

  assign node_sel         = node_addr[NODE_SEL_W-1:0];
  assign unused_addr_bits = ^node_addr[ADDR_W-1:NODE_SEL_W];

  abus_strobe_sync u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_async (frame_strobe),
    .strobe_rise  (strobe_rise)
  );

  abus_bit_timer #(
    .BIT_CYC    (BIT_CYC),
    .FRAME_BITS (FRAME_BITS),
    .IDX_W      (IDX_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (strobe_rise),
    .active  (frame_active),
    .bit_idx (bit_idx)
  );

  abus_tx_buffer #(
    .SAMPLE_W (SAMPLE_W),
    .DATA_W   (DATA_W),
    .SLOTS    (SLOTS),
    .SLOT_W   (SLOT_W)
  ) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_slot     (wr_slot),
    .wr_data     (wr_data),
    .capture     (strobe_rise),
    .frame_words (frame_words)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_ser
    abus_frame_ser #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
    ) u_ser (
      .word    (frame_words[s]),
      .bit_idx (bit_idx),
      .bit_val (slot_bits[s])
    );
  end

  abus_lane_drive #(
    .N_LANES (LANES),
    .N_SLOTS (SLOTS)
  ) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .node_sel  (node_sel),
    .active    (frame_active),
    .slot_bits (slot_bits),
    .lane_out  (lane_out),
    .lane_oe   (lane_oe)
  );

  // R2: number of enabled lanes follows the node address
  p_lane_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(lane_oe) == lanes_owned($past(node_sel))));

  // R3: no frame in progress means every lane rests high
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |=> (&lane_out));

  // R3: a lane without enable is never pulled low
  p_quiet_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~lane_oe & ~lane_out) == '0));

  // R4: the start bit drives every owned lane low
  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && bit_idx == IDX_W'(1)) |=> ((lane_out & lane_oe) == '0));

endmodule

// File: tb/abus_tx_top_tb.sv
module abus_tx_top_tb;

  localparam int BC = 4;
  localparam int NB = 19;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe;
  logic [3:0]  addr;
  logic        wr_en;
  logic        wr_slot;
  logic [23:0] wr_data;
  logic [7:0]  lo;
  logic [7:0]  oe;

  int n_vec = 0;
  int n_bad = 0;
  logic [23:0] m0, m1;

  always #5 clk = ~clk;

  abus_tx_top #(.BIT_CYC(BC)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_strobe (strobe),
    .node_addr    (addr),
    .wr_en        (wr_en),
    .wr_slot      (wr_slot),
    .wr_data      (wr_data),
    .lane_out     (lo),
    .lane_oe      (oe)
  );

  function automatic logic [7:0] exp_oe(input logic [3:0] a);
    int n;
    n = int'(a[2:0]);
    if (n == 0) return 8'b0000_0011;
    if (n == 7) return 8'b0000_0000;
    return 8'(1 << (n + 1));
  endfunction

  function automatic logic [7:0] exp_lanes(input logic [3:0] a, input logic [23:0] w0,
                                           input logic [23:0] w1, input int k);
    logic [7:0] v;
    logic [7:0] en;
    logic [15:0] d;
    en = exp_oe(a);
    v = 8'hFF;
    for (int l = 0; l < 8; l++) begin
      if (en[l]) begin
        d = (a[2:0] == 3'd0 && l == 1) ? w1[23:8] : w0[23:8];
        if (k == 0)       v[l] = 1'b1;
        else if (k == 1)  v[l] = 1'b0;
        else if (k < 18)  v[l] = d[k-2];
        else begin
          int ones = 0;
          for (int b = 0; b < 16; b++) ones += int'(d[b]);
          v[l] = (ones % 2 == 1);
        end
      end
    end
    return v;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_word(input logic slot, input logic [23:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = slot; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (slot) m1 = data; else m0 = data;
  endtask

  task automatic run_frame(input string req, input bit mid_en, input logic mid_slot,
                           input logic [23:0] mid_data);
    logic [23:0] f0, f1;
    f0 = m0; f1 = m1;
    @(negedge clk);
    strobe = 1'b1;
    repeat (4 + BC/2) @(posedge clk);
    for (int k = 0; k < NB; k++) begin
      @(negedge clk);
      check8(req, lo, exp_lanes(addr, f0, f1, k));
      if (k == 0) check8("R2", oe, exp_oe(addr));
      if (mid_en && k == 9) begin
        wr_en = 1'b1; wr_slot = mid_slot; wr_data = mid_data;
        @(posedge clk);
        #1 wr_en = 1'b0;
        if (mid_slot) m1 = mid_data; else m0 = mid_data;
        repeat (BC - 1) @(posedge clk);
      end else begin
        repeat (BC) @(posedge clk);
      end
    end
    @(negedge clk);
    check8("R3", lo, 8'hFF);
    strobe = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe = 1'b0; addr = 4'd0;
    wr_en = 1'b0; wr_slot = 1'b0; wr_data = '0;
    m0 = '0; m1 = '0;
    repeat (3) @(negedge clk);
    check8("R1", lo, 8'hFF);
    check8("R1", oe, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check8("R1", lo, 8'hFF);
    check8("R2", oe, exp_oe(addr));

    // R2 R7: every node address, slot 1 written for all
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      addr = 4'(a);
      write_word(1'b0, {8'(a * 37 + 5), 8'(a ^ 8'hC6), 8'h5A});
      write_word(1'b1, {8'(a * 11 + 129), 8'(~a), 8'hA5});
      run_frame("R7", 1'b0, 1'b0, '0);
    end

    // R4 R6: walking ones and dense patterns, master and a single-lane node
    for (int sel = 0; sel < 2; sel++) begin
      @(negedge clk);
      addr = (sel == 0) ? 4'd0 : 4'd3;
      for (int b = 0; b < 18; b++) begin
        logic [23:0] w;
        if (b < 16) w = 24'(1) << (b + 8);
        else if (b == 16) w = 24'hFFFFFF;
        else w = 24'h000000;
        write_word(1'b0, w);
        write_word(1'b1, ~w);
        run_frame("R6", 1'b0, 1'b0, '0);
      end
    end

    // R5: low byte has no effect
    @(negedge clk);
    addr = 4'd2;
    write_word(1'b0, 24'h3C5A00);
    run_frame("R5", 1'b0, 1'b0, '0);
    write_word(1'b0, 24'h3C5AFF);
    run_frame("R5", 1'b0, 1'b0, '0);

    // R9: no new write repeats the word
    run_frame("R9", 1'b0, 1'b0, '0);

    // R8: replacement before the strobe, then a write during a frame
    @(negedge clk);
    addr = 4'd0;
    write_word(1'b0, 24'h123400);
    write_word(1'b0, 24'hBEEF00);
    write_word(1'b1, 24'h0F0F00);
    run_frame("R8", 1'b1, 1'b0, 24'h7E8100);
    run_frame("R8", 1'b1, 1'b1, 24'hC3C300);
    run_frame("R8", 1'b0, 1'b0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule